// File: doc/BRIEF.md
# Half-Duplex Link Turnaround Scheduler

This block decides, cycle by cycle, whether a single-wire half-duplex debug link is listening or talking. It sits between the access layer, which produces response bytes, and a bit-level serializer, which shifts them onto the wire. The serializer, the baud generator and command decoding lie outside it. An eight-bit control register sets five behaviours. It picks a turnaround guard length, which holds the line quiet before the first byte that follows a reception. It can add an idle gap between the bytes of a multi-byte read response. It can switch off the response deadline. It can drop acknowledge bytes. It can ignore failed parity on received bytes.

All timed intervals count ticks of `link_tick`, the link clock enable. One shared counter clears whenever the controller enters a new state. The controller has six states. `S_RX` listens. `S_WAIT` waits for the access layer and runs the deadline. `S_GUARD` times the turnaround. `S_SEND` offers a byte to the serializer. `S_BUSY` waits for the serializer to finish. `S_GAP` times the inter-byte idle.

The transitions are as follows:
- RX to WAIT when `rsp_due` is pulsed.
- WAIT to GUARD when a byte is accepted and the line is still receiving.
- WAIT to SEND when a byte is accepted and the line is already transmitting.
- WAIT to RX when a suppressed acknowledge is dropped, or when the deadline expires.
- GUARD to SEND when the guard count is reached.
- SEND to BUSY on `ser_start`.
- BUSY to RX on `ser_done` for the last byte.
- BUSY to GAP on `ser_done` for a non-last byte with the gap enabled.
- BUSY to WAIT on `ser_done` for a non-last byte with the gap disabled.
- GAP to WAIT when the gap count is reached.

Top module: `hdx_dir_ctrl`

## Requirements
- R1: After reset the control register is 0x00. `drv_en`, `ser_req`, `tx_ack`, `err_tmo` and `err_par` are low, and the first turnaround uses the 128-tick guard.
- R2: Control bits [2:0] pick the guard length: code 0 gives 128 ticks, 1 gives 64, 2 gives 32, 3 gives 16, 4 gives 8, 5 gives 4 and 6 gives 2. With `link_tick` held high, `ser_req` rises guard+1 cycles after the cycle in which `tx_ack` is high.
- R3: Code 7 gives the same 128-tick guard as code 0.
- R4: The guard applies only when the line turns from receive to transmit. A byte accepted while the line is already transmitting reaches `ser_req` one cycle after `tx_ack`.
- R5: The guard length is captured when the guard starts. A control write during a guard does not change that guard, but it does set the next one.
- R6: With control bit 7 set, a non-last byte is followed by an idle gap of 2×`BIT_CYC` ticks, so the next `ser_req` comes 2×`BIT_CYC`+2 cycles after `ser_done`. With bit 7 clear the delay is 2 cycles.
- R7: With control bit 4 clear, waiting `TMO_CYC` ticks (65536) for the access layer raises `err_tmo` for one cycle, exactly `TMO_CYC`+1 cycles after `rsp_due`. The controller then returns to receive and acknowledges no byte.
- R8: With control bit 4 set, the wait has no deadline and never raises `err_tmo`.
- R9: With control bit 3 set, a byte marked `tx_is_ack` is consumed through `tx_ack` but never offered to the serializer, and the line stays in receive.
- R10: With control bit 5 clear, a received byte with failed parity pulses `err_par` in the following cycle and cancels a `rsp_due` that arrives in the same cycle. With bit 5 set, failed parity raises no error.
- R11: The guard and gap counters advance only on cycles with `link_tick` high. Each low cycle during a guard delays `ser_req` by one cycle.
- R12: `ser_req` holds with a stable `ser_data` until `ser_start`. `drv_en` is high from `ser_req` until the last byte's `ser_done`, and stays high between the bytes of one response. Bytes reach the serializer in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_tick | input | 1 | Link clock enable; all timed counts advance on it |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| rx_byte_vld | input | 1 | A byte was received this cycle |
| rx_par_ok | input | 1 | Parity check result for that byte |
| rsp_due | input | 1 | Access layer will send a response; starts the wait |
| tx_req | input | 1 | Access layer offers a byte |
| tx_data | input | 8 | Offered byte |
| tx_last | input | 1 | Offered byte ends the response |
| tx_is_ack | input | 1 | Offered byte is an acknowledge signature |
| tx_ack | output | 1 | Offered byte taken this cycle |
| ser_req | output | 1 | Byte ready for the serializer |
| ser_data | output | 8 | Byte for the serializer |
| ser_start | input | 1 | Serializer took the byte |
| ser_done | input | 1 | Serializer finished the byte |
| drv_en | output | 1 | Line held in transmit direction |
| err_tmo | output | 1 | One-cycle pulse: response deadline missed |
| err_par | output | 1 | One-cycle pulse: parity failure flagged |

## Verification
The bench times every turnaround for each guard code, the reserved code included. An off-by-one counter, or a decode that reverses the shift, shows up as a latency one cycle off or a factor of two off. It sends a three-byte response, with the gap switched off and then on. A design that re-applies the guard between bytes, or loses the gap, moves the measured distance from `ser_done` to `ser_req`. It rewrites the guard code in the middle of a guard and stalls `link_tick` during another. A design that reads the register live would shorten the first guard, and one that counts plain cycles would ignore the stall. It also runs the full 65536-tick deadline with the check on and off, drops an acknowledge byte with signatures off, and raises a parity failure together with `rsp_due`. A design that mishandles these reports a late or missing timeout, sends a stray byte to the serializer, or starts a response that should have been cancelled.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    // Controller states.
    typedef enum logic [2:0] {
        S_RX    = 3'd0,
        S_WAIT  = 3'd1,
        S_GUARD = 3'd2,
        S_SEND  = 3'd3,
        S_BUSY  = 3'd4,
        S_GAP   = 3'd5
    } hdx_state_t;

    // Decoded control register.
    typedef struct packed {
        logic       gap_en;     // bit 7
        logic       par_ign;    // bit 5
        logic       tmo_off;    // bit 4
        logic       sig_off;    // bit 3
        logic [2:0] grd_code;   // bits 2:0
    } hdx_cfg_t;

    // Guard length in ticks for a code: halves per step, top code falls back to base.
    function automatic int guard_ticks(input logic [2:0] code, input int base);
        if (code == 3'd7) begin
            return base;
        end
        return base >> code;
    endfunction

endpackage

// File: rtl/hdx_cfg_reg.sv
module hdx_cfg_reg
    import hdx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output hdx_cfg_t   cfg
);

    hdx_cfg_t cfg_q;
    hdx_cfg_t cfg_w;

    // Bit 6 carries nothing and is dropped.
    always_comb begin
        cfg_w.gap_en   = wdata[7];
        cfg_w.par_ign  = wdata[5];
        cfg_w.tmo_off  = wdata[4];
        cfg_w.sig_off  = wdata[3];
        cfg_w.grd_code = wdata[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_w;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/hdx_guard_lat.sv
module hdx_guard_lat
    import hdx_pkg::*;
#(
    parameter int GUARD_BASE = 128,
    parameter int GL_W       = $clog2(GUARD_BASE) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [2:0]      code,
    output logic [GL_W-1:0] glen
);

    logic [GL_W-1:0] glen_q;
    logic [GL_W-1:0] glen_d;

    always_comb begin
        glen_d = GL_W'(guard_ticks(code, GUARD_BASE));
    end

    // Snapshot on guard entry so later writes cannot disturb a running guard.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glen_q <= GL_W'(GUARD_BASE);
        end else if (load) begin
            glen_q <= glen_d;
        end
    end

    assign glen = glen_q;

endmodule

// File: rtl/hdx_span_ctr.sv
module hdx_span_ctr #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);

    localparam logic [W-1:0] CNT_TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // Final tick of a span of `limit` ticks.
    assign hit = tick && (cnt_q == (limit - W'(1)));

endmodule

// File: rtl/hdx_dir_ctrl.sv
module hdx_dir_ctrl
    import hdx_pkg::*;
#(
    parameter int GUARD_BASE = 128,
    parameter int BIT_CYC    = 8,
    parameter int IDLE_BITS  = 2,
    parameter int TMO_CYC    = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_tick,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       rx_byte_vld,
    input  logic       rx_par_ok,
    input  logic       rsp_due,
    input  logic       tx_req,
    input  logic [7:0] tx_data,
    input  logic       tx_last,
    input  logic       tx_is_ack,
    output logic       tx_ack,
    output logic       ser_req,
    output logic [7:0] ser_data,
    input  logic       ser_start,
    input  logic       ser_done,
    output logic       drv_en,
    output logic       err_tmo,
    output logic       err_par
);

    localparam int GL_W    = $clog2(GUARD_BASE) + 1;
    localparam int CNT_W   = $clog2(TMO_CYC) + 1;
    localparam int GAP_CYC = IDLE_BITS * BIT_CYC;

    hdx_state_t      state_q, state_d;
    hdx_cfg_t        cfg;
    logic [GL_W-1:0] glen;
    logic [CNT_W-1:0] span_lim;
    logic            span_hit;
    logic            span_clr;
    logic            grd_load;
    logic            line_tx_q;
    logic [7:0]      byte_q;
    logic            last_q;
    logic            tmo_now;
    logic            par_bad;
    logic            err_tmo_q, err_par_q;

    hdx_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    hdx_guard_lat #(
        .GUARD_BASE (GUARD_BASE),
        .GL_W       (GL_W)
    ) u_grd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (grd_load),
        .code  (cfg.grd_code),
        .glen  (glen)
    );

    hdx_span_ctr #(
        .W (CNT_W)
    ) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (span_clr),
        .tick  (link_tick),
        .limit (span_lim),
        .hit   (span_hit)
    );

    // Each counting state picks its own span length.
    always_comb begin
        unique case (state_q)
            S_GUARD: span_lim = CNT_W'(glen);
            S_GAP:   span_lim = CNT_W'(GAP_CYC);
            S_WAIT:  span_lim = CNT_W'(TMO_CYC);
            default: span_lim = '1;
        endcase
    end

    assign par_bad  = rx_byte_vld && !rx_par_ok && !cfg.par_ign;
    assign tmo_now  = (state_q == S_WAIT) && !tx_req && !cfg.tmo_off && span_hit;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RX: begin
                if (!par_bad && rsp_due) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (tx_req) begin
                    if (tx_is_ack && cfg.sig_off) begin
                        state_d = S_RX;
                    end else if (line_tx_q) begin
                        state_d = S_SEND;
                    end else begin
                        state_d = S_GUARD;
                    end
                end else if (tmo_now) begin
                    state_d = S_RX;
                end
            end
            S_GUARD: begin
                if (span_hit) begin
                    state_d = S_SEND;
                end
            end
            S_SEND: begin
                if (ser_start) begin
                    state_d = S_BUSY;
                end
            end
            S_BUSY: begin
                if (ser_done) begin
                    if (last_q) begin
                        state_d = S_RX;
                    end else if (cfg.gap_en) begin
                        state_d = S_GAP;
                    end else begin
                        state_d = S_WAIT;
                    end
                end
            end
            S_GAP: begin
                if (span_hit) begin
                    state_d = S_WAIT;
                end
            end
            default: state_d = S_RX;
        endcase
    end

    assign span_clr = (state_d != state_q);
    assign grd_load = (state_d == S_GUARD) && (state_q != S_GUARD);

    // State register with its companion flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_RX;
            line_tx_q <= 1'b0;
            byte_q    <= '0;
            last_q    <= 1'b0;
            err_tmo_q <= 1'b0;
            err_par_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            err_tmo_q <= tmo_now;
            err_par_q <= (state_q == S_RX) && par_bad;
            if (state_d == S_RX) begin
                line_tx_q <= 1'b0;
            end else if (state_d == S_SEND) begin
                line_tx_q <= 1'b1;
            end
            if (tx_ack) begin
                byte_q <= tx_data;
                last_q <= tx_last;
            end
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        tx_ack   = 1'b0;
        ser_req  = 1'b0;
        drv_en   = 1'b0;
        unique case (state_q)
            S_RX:    ;
            S_WAIT: begin
                tx_ack = tx_req;
                drv_en = line_tx_q;
            end
            S_GUARD: ;
            S_SEND: begin
                ser_req = 1'b1;
                drv_en  = 1'b1;
            end
            S_BUSY:  drv_en = 1'b1;
            S_GAP:   drv_en = 1'b1;
            default: ;
        endcase
    end

    assign ser_data = byte_q;
    assign err_tmo  = err_tmo_q;
    assign err_par  = err_par_q;

endmodule

// File: rtl/hdx_dir_ctrl_chk.sv
module hdx_dir_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       link_tick,
    input logic       rx_byte_vld,
    input logic       rx_par_ok,
    input logic       tx_req,
    input logic       tx_ack,
    input logic       ser_req,
    input logic [7:0] ser_data,
    input logic       ser_start,
    input logic       drv_en,
    input logic       err_tmo,
    input logic       err_par
);

    // R12
    ser_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_req && !ser_start |=> ser_req);

    // R12
    ser_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_req && !ser_start |=> $stable(ser_data));

    // R12
    req_drives_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_req |-> drv_en);

    // R9
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> tx_req);

    // R9
    ack_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |=> !tx_ack);

    // R7
    tmo_releases_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> (!drv_en && !ser_req));

    // R7
    tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |=> !err_tmo);

    // R10
    good_parity_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_vld && rx_par_ok |=> !err_par);

    // R11
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_req) |-> ($past(link_tick) || $past(tx_ack)));

endmodule

bind hdx_dir_ctrl hdx_dir_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_tick   (link_tick),
    .rx_byte_vld (rx_byte_vld),
    .rx_par_ok   (rx_par_ok),
    .tx_req      (tx_req),
    .tx_ack      (tx_ack),
    .ser_req     (ser_req),
    .ser_data    (ser_data),
    .ser_start   (ser_start),
    .drv_en      (drv_en),
    .err_tmo     (err_tmo),
    .err_par     (err_par)
);

// File: tb/hdx_dir_ctrl_bench.sv
`timescale 1ns/1ps
module hdx_dir_ctrl_bench;

    localparam int TMO  = 65536;
    localparam int BITC = 8;
    localparam int GAPC = 2 * BITC;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       link_tick, cfg_we, rx_byte_vld, rx_par_ok, rsp_due;
    logic       tx_req, tx_last, tx_is_ack, ser_start, ser_done;
    logic [7:0] cfg_wdata, tx_data;
    logic       tx_ack, ser_req, drv_en, err_tmo, err_par;
    logic [7:0] ser_data;

    always #2.5 clk = ~clk;

    hdx_dir_ctrl u_hdx_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .link_tick(link_tick),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_byte_vld(rx_byte_vld), .rx_par_ok(rx_par_ok), .rsp_due(rsp_due),
        .tx_req(tx_req), .tx_data(tx_data), .tx_last(tx_last), .tx_is_ack(tx_is_ack),
        .tx_ack(tx_ack), .ser_req(ser_req), .ser_data(ser_data),
        .ser_start(ser_start), .ser_done(ser_done),
        .drv_en(drv_en), .err_tmo(err_tmo), .err_par(err_par)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] exp_b;
    int n_req = 0;
    int req_cyc = 0;
    int done_cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Serializer model and scoreboard monitor.
    initial begin
        ser_start = 1'b0;
        ser_done  = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && ser_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected serializer byte", int'(ser_data), -1);
                end else begin
                    exp_b = exp_q.pop_front();
                    chk(ser_data == exp_b, "R12 byte order", int'(ser_data), int'(exp_b));
                end
                req_cyc = cyc;
                n_req++;
                ser_start = 1'b1;
                @(negedge clk);
                ser_start = 1'b0;
                repeat (3) @(negedge clk);
                ser_done = 1'b1;
                done_cyc = cyc;
                @(negedge clk);
                ser_done = 1'b0;
            end
        end
    end

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic due(output int c0);
        @(negedge clk);
        rsp_due = 1'b1;
        c0 = cyc;
        @(negedge clk);
        rsp_due = 1'b0;
    endtask

    // Driver: offers a byte, records expectation, returns the acknowledge cycle.
    task automatic push(input logic [7:0] d, input bit last, input bit is_ack,
                        input bit sent, output int ack_c);
        int w;
        w = 0;
        tx_req = 1'b1;
        tx_data = d;
        tx_last = last;
        tx_is_ack = is_ack;
        if (sent) exp_q.push_back(d);
        #1;
        while (!tx_ack && w < 2000) begin
            @(negedge clk);
            #1;
            w++;
        end
        if (w >= 2000) chk(1'b0, "R9 byte never acknowledged", 0, 1);
        ack_c = cyc;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic wait_req(input int prev, output int c);
        int w;
        w = 0;
        while (n_req == prev && w < 2000) begin
            @(negedge clk);
            #1;
            w++;
        end
        c = req_cyc;
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        @(negedge clk);
        while ((drv_en || ser_done) && w < 2000) begin
            @(negedge clk);
            w++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic one_resp(input logic [7:0] d, input int exp_lat, input string tag);
        int c0, a, r, p;
        p = n_req;
        due(c0);
        push(d, 1'b1, 1'b1, 1'b1, a);
        wait_req(p, r);
        chk(r - a == exp_lat, tag, r - a, exp_lat);
        wait_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c0, a, r, p, hits;
        rst_n = 1'b0; link_tick = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        rx_byte_vld = 1'b0; rx_par_ok = 1'b1; rsp_due = 1'b0;
        tx_req = 1'b0; tx_data = '0; tx_last = 1'b0; tx_is_ack = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        chk(!drv_en && !ser_req && !tx_ack && !err_tmo && !err_par, "R1 reset outputs",
            {drv_en, ser_req, tx_ack, err_tmo, err_par}, 0);
        // R1 reset guard is 128
        one_resp(8'h40, 129, "R1 reset guard latency");

        // R2 every defined code
        for (int k = 1; k < 7; k++) begin
            wr_cfg(8'(k));
            one_resp(8'(8'h50 + k), (128 >> k) + 1, "R2 guard code latency");
        end
        // R3 reserved code
        wr_cfg(8'h07);
        one_resp(8'h57, 129, "R3 reserved code latency");

        // R5 write mid-guard keeps current guard, sets the next
        wr_cfg(8'h00);
        p = n_req;
        due(c0);
        push(8'h60, 1'b1, 1'b1, 1'b1, a);
        wr_cfg(8'h06);
        wait_req(p, r);
        chk(r - a == 129, "R5 running guard unchanged", r - a, 129);
        wait_idle();
        one_resp(8'h61, 3, "R5 new guard on next turnaround");

        // R11 stalled ticks during guard
        p = n_req;
        due(c0);
        push(8'h62, 1'b1, 1'b1, 1'b1, a);
        link_tick = 1'b0;
        repeat (10) @(negedge clk);
        link_tick = 1'b1;
        wait_req(p, r);
        chk(r - a == 13, "R11 guard frozen without tick", r - a, 13);
        wait_idle();

        // R4 / R6 multi-byte response, gap off then on
        wr_cfg(8'h03);
        p = n_req;
        due(c0);
        push(8'h71, 1'b0, 1'b0, 1'b1, a);
        wait_req(p, r);
        chk(r - a == 17, "R4 first byte guarded", r - a, 17);
        p = n_req;
        push(8'h72, 1'b0, 1'b0, 1'b1, a);
        chk(a - done_cyc == 1, "R4 no guard inside response", a - done_cyc, 1);
        wait_req(p, r);
        chk(r - done_cyc == 2, "R6 gap off spacing", r - done_cyc, 2);
        chk(drv_en == 1'b1, "R12 line held between bytes", drv_en, 1);
        wr_cfg(8'h83);
        p = n_req;
        push(8'h73, 1'b1, 1'b0, 1'b1, a);
        wait_req(p, r);
        chk(r - done_cyc == GAPC + 2, "R6 gap on spacing", r - done_cyc, GAPC + 2);
        wait_idle();
        chk(drv_en == 1'b0, "R12 line released after last byte", drv_en, 0);

        // R9 acknowledge suppressed
        wr_cfg(8'h0E);
        p = n_req;
        due(c0);
        push(8'hA5, 1'b1, 1'b1, 1'b0, a);
        repeat (20) @(negedge clk);
        chk(n_req == p, "R9 no serializer request", n_req - p, 0);
        chk(drv_en == 1'b0, "R9 line stays receive", drv_en, 0);

        // R10 parity
        wr_cfg(8'h06);
        @(negedge clk);
        rx_byte_vld = 1'b1; rx_par_ok = 1'b0; rsp_due = 1'b1;
        @(negedge clk);
        rx_byte_vld = 1'b0; rx_par_ok = 1'b1; rsp_due = 1'b0;
        chk(err_par == 1'b1, "R10 parity error pulse", err_par, 1);
        tx_req = 1'b1;
        #1;
        chk(tx_ack == 1'b0, "R10 due cancelled by parity error", tx_ack, 0);
        tx_req = 1'b0;
        @(negedge clk);
        chk(err_par == 1'b0, "R10 pulse one cycle", err_par, 0);
        wr_cfg(8'h26);
        @(negedge clk);
        rx_byte_vld = 1'b1; rx_par_ok = 1'b0;
        @(negedge clk);
        rx_byte_vld = 1'b0; rx_par_ok = 1'b1;
        chk(err_par == 1'b0, "R10 parity ignored", err_par, 0);

        // R7 deadline
        wr_cfg(8'h06);
        due(c0);
        hits = 0;
        while (!err_tmo && hits < 70000) begin
            @(negedge clk);
            hits++;
        end
        chk(cyc - c0 == TMO + 1, "R7 timeout cycle", cyc - c0, TMO + 1);
        tx_req = 1'b1;
        #1;
        chk(tx_ack == 1'b0 && drv_en == 1'b0, "R7 back to receive", tx_ack, 0);
        tx_req = 1'b0;
        @(negedge clk);
        chk(err_tmo == 1'b0, "R7 pulse one cycle", err_tmo, 0);

        // R8 deadline disabled
        wr_cfg(8'h16);
        due(c0);
        hits = 0;
        repeat (66000) begin
            @(negedge clk);
            if (err_tmo) hits++;
        end
        chk(hits == 0, "R8 no timeout when disabled", hits, 0);
        p = n_req;
        push(8'h99, 1'b1, 1'b1, 1'b1, a);
        wait_req(p, r);
        chk(r - a == 3, "R8 response still served", r - a, 3);
        wait_idle();

        chk(exp_q.size() == 0, "R12 all expected bytes sent", exp_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule